// File: doc/BRIEF.md
# Beam Loss Threshold Fault Checker

This block watches the charge results produced for a bank of loss-monitor channels. It compares each result against limits that software programs, and it keeps one latched fault word per channel. Five charge quantities arrive for every channel: the single-pulse charge and four running sums over windows of 1/60 s, 1/30 s, 1/10 s and 1 s. Each of these is tested against the same pair of 16-bit channel thresholds. A sixth quantity, the LED test charge, must stay inside a window set by a low limit and a high limit.

Results arrive one at a time on an update port. Each update carries a channel number, a kind code and a value. Only the quantity that was strobed is compared, and any fault found is latched. A fault bit stays set until software writes a one to it. A single registered summary line reports whether any latched bit is set in any channel. That line can drive the machine-protection fault input directly.

Top module: `blm_fault_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every fault word and `fault_any` become 0. Thresholds return to 0xFFFF for both charge limits, 0 for the test low limit and 0xFFFF for the test high limit.
- R2: An update of kind k selects one charge quantity: 0 is the pulse, 1 is the 1/60 s sum, 2 is the 1/30 s sum, 3 is the 1/10 s sum and 4 is the 1 s sum. For k in 0 to 4, the update sets bit 2k of the channel word when the value is strictly greater than threshold 0. It sets bit 2k+1 when the value is strictly greater than threshold 1. A value equal to a threshold sets nothing. The bit is visible after the clock edge that samples the update.
- R3: Values are Q_W bits wide (24 by default), and the 16-bit thresholds are zero-extended before the compare. A value of 0x10000 or more therefore exceeds any threshold.
- R4: An update of kind 5 carries the test charge. It sets bit 10 when the value is below the low limit and bit 11 when the value is above the high limit. A value equal to either limit sets neither bit.
- R5: Comparisons happen only on an update strobe. Writing a limit does not change any fault bit, so the test limits are applied only when a kind-5 update arrives. Kind codes 6 and 7 are ignored.
- R6: Fault bits hold their value until a clear write names the channel and carries a one in that bit position of `clr_mask`. Mask bits that are 0 leave their fault bits unchanged.
- R7: If a clear and a new fault hit the same bit in the same cycle, the bit ends up set.
- R8: `fault_any` is the OR of all latched fault bits of all channels, delayed by one register stage.
- R9: An update or clear for one channel never changes the fault word of another channel.
- R10: A limit write uses `cfg_sel` 0 for threshold 0, 1 for threshold 1, 2 for the test low limit and 3 for the test high limit. It takes effect after its clock edge. An update in the same cycle is compared against the limit held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Limit write strobe |
| cfg_ch | input | CH_W | Channel of the limit write |
| cfg_sel | input | 2 | Which limit is written (0 thr0, 1 thr1, 2 test low, 3 test high) |
| cfg_wdata | input | 16 | Limit value |
| clr_we | input | 1 | Fault clear strobe |
| clr_ch | input | CH_W | Channel whose fault bits are cleared |
| clr_mask | input | 12 | Write-one-to-clear mask |
| upd_valid | input | 1 | Charge update strobe |
| upd_ch | input | CH_W | Channel of the update |
| upd_kind | input | 3 | Quantity code (0 to 5, others ignored) |
| upd_value | input | Q_W | Charge value |
| fault_words | output | N_CH*12 | Latched fault words, channel c at bits [12c+11:12c] |
| fault_any | output | 1 | Registered OR of all latched fault bits |

## Verification
Two pairs of functions can land in the same cycle. In the first pair, a clear and a fresh fault hit the same bit. In the second, a limit write and an update arrive together on one channel. The bench drives each pair in a single cycle on purpose. It expects the set to win over the clear, and it expects the compare to use the limit held before the write. A behavioural model applies the same ordering while random traffic mixes writes, clears and updates, and every cycle is compared against that model.

// File: rtl/blm_fc_pkg.sv
// Package: shared types and constants for the beam loss threshold fault checker.
// Assumes a fixed 12-bit fault layout: two bits per charge window, then test low/high.
package blm_fc_pkg;

    localparam int THR_W   = 16;
    localparam int N_WIN   = 5;
    localparam int FW      = 2 * N_WIN + 2;
    localparam int BIT_TLO = 2 * N_WIN;
    localparam int BIT_THI = 2 * N_WIN + 1;

    typedef enum logic [2:0] {
        K_PULSE = 3'd0,
        K_W60   = 3'd1,
        K_W30   = 3'd2,
        K_W10   = 3'd3,
        K_W1    = 3'd4,
        K_TEST  = 3'd5
    } charge_kind_e;

    typedef enum logic [1:0] {
        SEL_THR0 = 2'd0,
        SEL_THR1 = 2'd1,
        SEL_TLO  = 2'd2,
        SEL_THI  = 2'd3
    } thr_sel_e;

    typedef struct packed {
        logic [THR_W-1:0] thr0;
        logic [THR_W-1:0] thr1;
        logic [THR_W-1:0] tlo;
        logic [THR_W-1:0] thi;
    } thr_set_t;

    localparam thr_set_t THR_RESET = '{thr0: '1, thr1: '1, tlo: '0, thi: '1};

endpackage

// File: rtl/blm_thr_bank.sv
// Module: per-channel limit register bank.
// Holds two charge thresholds and the test window limits for every channel.
// Assumes one write per cycle; channel numbers at or above N_CH are dropped.
module blm_thr_bank
    import blm_fc_pkg::*;
#(
    parameter int N_CH = 8,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CH_W-1:0]        wr_ch,
    input  logic [1:0]             wr_sel,
    input  logic [THR_W-1:0]       wr_data,
    output thr_set_t [N_CH-1:0]    thr_q
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CH_W'(c));

        // Update the addressed limit of this channel on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                thr_q[c] <= THR_RESET;
            end else if (hit) begin
                case (thr_sel_e'(wr_sel))
                    SEL_THR0: thr_q[c].thr0 <= wr_data;
                    SEL_THR1: thr_q[c].thr1 <= wr_data;
                    SEL_TLO:  thr_q[c].tlo  <= wr_data;
                    default:  thr_q[c].thi  <= wr_data;
                endcase
            end
        end
    end

endmodule

// File: rtl/blm_cmp_unit.sv
// Module: compare stage shared by all channels.
// Turns one strobed charge value into a 12-bit vector of new fault bits.
// Assumes thresholds are zero-extended to Q_W; the compare is purely combinational.
module blm_cmp_unit
    import blm_fc_pkg::*;
#(
    parameter int Q_W = 24
) (
    input  logic             valid,
    input  logic [2:0]       kind,
    input  logic [Q_W-1:0]   value,
    input  thr_set_t         thr,
    output logic [FW-1:0]    set_vec
);

    logic [Q_W-1:0] thr0_x, thr1_x, tlo_x, thi_x;

    // Widen all limits to the charge width.
    always_comb begin
        thr0_x = Q_W'(thr.thr0);
        thr1_x = Q_W'(thr.thr1);
        tlo_x  = Q_W'(thr.tlo);
        thi_x  = Q_W'(thr.thi);
    end

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        logic sel;
        assign sel = valid && (kind == 3'(w));
        // Threshold pair for charge window w.
        always_comb begin
            set_vec[2*w]   = sel && (value > thr0_x);
            set_vec[2*w+1] = sel && (value > thr1_x);
        end
    end

    logic sel_test;
    assign sel_test = valid && (charge_kind_e'(kind) == K_TEST);

    // Window check on the test charge.
    always_comb begin
        set_vec[BIT_TLO] = sel_test && (value < tlo_x);
        set_vec[BIT_THI] = sel_test && (value > thi_x);
    end

endmodule

// File: rtl/blm_fault_reg.sv
// Module: one channel's latched fault word.
// Bits set on a detected fault and clear on write-one; a set wins over a clear.
// Assumes set and clear vectors are already gated to this channel.
module blm_fault_reg
    import blm_fc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [FW-1:0]  set_vec,
    input  logic [FW-1:0]  clr_vec,
    output logic [FW-1:0]  word
);

    // Latch new faults, drop cleared ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else begin
            word <= (word & ~clr_vec) | set_vec;
        end
    end

endmodule

// File: rtl/blm_fault_checker.sv
// Module: top of the beam loss threshold fault checker.
// Routes each update to the shared compare stage using that channel's limits,
// latches faults per channel, and registers an OR of every fault bit.
// Assumes one update, one limit write and one clear per cycle at most.
module blm_fault_checker
    import blm_fc_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int Q_W  = 24,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CH_W-1:0]       cfg_ch,
    input  logic [1:0]            cfg_sel,
    input  logic [15:0]           cfg_wdata,
    input  logic                  clr_we,
    input  logic [CH_W-1:0]       clr_ch,
    input  logic [11:0]           clr_mask,
    input  logic                  upd_valid,
    input  logic [CH_W-1:0]       upd_ch,
    input  logic [2:0]            upd_kind,
    input  logic [Q_W-1:0]        upd_value,
    output logic [N_CH*12-1:0]    fault_words,
    output logic                  fault_any
);

    thr_set_t [N_CH-1:0] thr_q;
    thr_set_t            thr_sel;
    logic                upd_ok;
    logic [FW-1:0]       set_vec;

    blm_thr_bank #(.N_CH(N_CH)) u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_ch   (cfg_ch),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .thr_q   (thr_q)
    );

    // Pick the limits of the updated channel; out-of-range channels are dropped.
    always_comb begin
        upd_ok  = upd_valid && (32'(upd_ch) < N_CH);
        thr_sel = THR_RESET;
        for (int c = 0; c < N_CH; c++) begin
            if (upd_ch == CH_W'(c)) thr_sel = thr_q[c];
        end
    end

    blm_cmp_unit #(.Q_W(Q_W)) u_cmp (
        .valid   (upd_ok),
        .kind    (upd_kind),
        .value   (upd_value),
        .thr     (thr_sel),
        .set_vec (set_vec)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [FW-1:0] ch_set, ch_clr;
        assign ch_set = (upd_ok && upd_ch == CH_W'(c)) ? set_vec : '0;
        assign ch_clr = (clr_we && clr_ch == CH_W'(c)) ? clr_mask : '0;

        blm_fault_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (ch_set),
            .clr_vec (ch_clr),
            .word    (fault_words[c*FW +: FW])
        );
    end

    // Registered summary of all latched faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_any <= 1'b0;
        end else begin
            fault_any <= |fault_words;
        end
    end

endmodule

// File: rtl/blm_fault_checker_sva.sv
// Module: assertion checker bound to the fault checker top.
// Observes ports only; builds channel masks locally for the clear and isolation checks.
module blm_fault_checker_sva #(
    parameter int N_CH = 8,
    parameter int Q_W  = 24,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [CH_W-1:0]       cfg_ch,
    input logic [1:0]            cfg_sel,
    input logic [15:0]           cfg_wdata,
    input logic                  clr_we,
    input logic [CH_W-1:0]       clr_ch,
    input logic [11:0]           clr_mask,
    input logic                  upd_valid,
    input logic [CH_W-1:0]       upd_ch,
    input logic [2:0]            upd_kind,
    input logic [Q_W-1:0]        upd_value,
    input logic [N_CH*12-1:0]    fault_words,
    input logic                  fault_any
);

    logic [N_CH*12-1:0] clr_bits;
    logic [N_CH*12-1:0] touch_win;

    // Bits named by this cycle's clear, and the windows this cycle may touch.
    always_comb begin
        clr_bits  = '0;
        touch_win = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (clr_we && clr_ch == CH_W'(c)) begin
                clr_bits[c*12 +: 12]  = clr_mask;
                touch_win[c*12 +: 12] = '1;
            end
            if (upd_valid && upd_ch == CH_W'(c)) touch_win[c*12 +: 12] = '1;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (fault_words == '0 && !fault_any));

    p_no_spont_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ((fault_words & ~$past(fault_words)) == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid && !clr_we) |=> $stable(fault_words));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !upd_valid) |=> ((fault_words & $past(clr_bits)) == '0));

    p_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fault_any == ($past(fault_words) != '0)));

    p_isolation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((fault_words ^ $past(fault_words)) & ~$past(touch_win)) == '0));

endmodule

bind blm_fault_checker blm_fault_checker_sva #(.N_CH(N_CH), .Q_W(Q_W)) u_sva (.*);

// File: tb/blm_fault_checker_tb.sv
module blm_fault_checker_tb;

    localparam int N_CH = 8;
    localparam int Q_W  = 24;
    localparam int CH_W = 3;
    localparam real TCK = 4.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 0;
    logic [CH_W-1:0]   cfg_ch = 0;
    logic [1:0]        cfg_sel = 0;
    logic [15:0]       cfg_wdata = 0;
    logic              clr_we = 0;
    logic [CH_W-1:0]   clr_ch = 0;
    logic [11:0]       clr_mask = 0;
    logic              upd_valid = 0;
    logic [CH_W-1:0]   upd_ch = 0;
    logic [2:0]        upd_kind = 0;
    logic [Q_W-1:0]    upd_value = 0;
    logic [N_CH*12-1:0] fault_words;
    logic              fault_any;

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 0;
    string cur_req = "R1";

    always #(TCK/2) clk = ~clk;

    blm_fault_checker #(.N_CH(N_CH), .Q_W(Q_W)) u_dut (.*);

    // Behavioural reference model.
    int          m_thr [N_CH][4];
    logic [11:0] m_fw  [N_CH];
    logic [11:0] m_set;
    bit          m_any;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) begin
                m_fw[c] = 0;
                m_thr[c][0] = 65535; m_thr[c][1] = 65535;
                m_thr[c][2] = 0;     m_thr[c][3] = 65535;
            end
            m_any = 0;
        end else begin
            m_any = 0;
            for (int c = 0; c < N_CH; c++) if (m_fw[c] != 0) m_any = 1;
            m_set = 0;
            if (upd_valid) begin
                int v;
                v = int'(upd_value);
                if (upd_kind <= 4) begin
                    if (v > m_thr[upd_ch][0]) m_set[2*upd_kind]   = 1;
                    if (v > m_thr[upd_ch][1]) m_set[2*upd_kind+1] = 1;
                end else if (upd_kind == 5) begin
                    if (v < m_thr[upd_ch][2]) m_set[10] = 1;
                    if (v > m_thr[upd_ch][3]) m_set[11] = 1;
                end
            end
            if (clr_we) m_fw[clr_ch] = m_fw[clr_ch] & ~clr_mask;
            if (upd_valid) m_fw[upd_ch] = m_fw[upd_ch] | m_set;
            if (cfg_we) m_thr[cfg_ch][cfg_sel] = int'(cfg_wdata);
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (running) begin
            for (int c = 0; c < N_CH; c++) begin
                n_cmp++;
                if (fault_words[c*12 +: 12] !== m_fw[c]) begin
                    n_bad++;
                    $display("FAIL %s model ch%0d: actual %h expected %h", cur_req, c,
                             fault_words[c*12 +: 12], m_fw[c]);
                end
            end
            n_cmp++;
            if (fault_any !== m_any) begin
                n_bad++;
                $display("FAIL %s model fault_any: actual %0b expected %0b", cur_req, fault_any, m_any);
            end
        end
    end

    task automatic chk(input int ch, input logic [11:0] exp, input string req);
        n_cmp++;
        if (fault_words[ch*12 +: 12] !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: actual %h expected %h", req, ch, fault_words[ch*12 +: 12], exp);
        end
    endtask

    task automatic chk_any(input bit exp, input string req);
        n_cmp++;
        if (fault_any !== exp) begin
            n_bad++;
            $display("FAIL %s fault_any: actual %0b expected %0b", req, fault_any, exp);
        end
    endtask

    task automatic drive(input bit uv, input int uch, input int uk, input int uval,
                         input bit cv, input int cch, input int csel, input int cval,
                         input bit kv, input int kch, input int kmask);
        @(negedge clk);
        upd_valid = uv; upd_ch = CH_W'(uch); upd_kind = 3'(uk); upd_value = Q_W'(uval);
        cfg_we = cv; cfg_ch = CH_W'(cch); cfg_sel = 2'(csel); cfg_wdata = 16'(cval);
        clr_we = kv; clr_ch = CH_W'(kch); clr_mask = 12'(kmask);
        @(negedge clk);
        upd_valid = 0; cfg_we = 0; clr_we = 0;
    endtask

    task automatic upd(input int ch, input int k, input int v);
        drive(1, ch, k, v, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic cfg(input int ch, input int s, input int v);
        drive(0, 0, 0, 0, 1, ch, s, v, 0, 0, 0);
    endtask
    task automatic clr(input int ch, input int m);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, ch, m);
    endtask
    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #(TCK * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        running = 1;
        for (int c = 0; c < N_CH; c++) chk(c, 12'h000, "R1");
        chk_any(0, "R1");

        cur_req = "R2";
        cfg(0, 0, 100); cfg(0, 1, 200);
        upd(0, 0, 100); chk(0, 12'h000, "R2");
        upd(0, 0, 150); chk(0, 12'h001, "R2");
        upd(0, 4, 201); chk(0, 12'h301, "R2");
        cur_req = "R8";
        idle(); chk_any(1, "R8");

        cur_req = "R6";
        clr(0, 12'h000); chk(0, 12'h301, "R6");
        clr(0, 12'h001); chk(0, 12'h300, "R6");

        cur_req = "R3";
        upd(1, 1, 'h10000); chk(1, 12'h00C, "R3");
        upd(1, 2, 'hFFFF);  chk(1, 12'h00C, "R3");

        cur_req = "R4";
        cfg(2, 2, 50); cfg(2, 3, 80);
        upd(2, 5, 50); chk(2, 12'h000, "R4");
        upd(2, 5, 80); chk(2, 12'h000, "R4");
        upd(2, 5, 49); chk(2, 12'h400, "R4");
        upd(2, 5, 81); chk(2, 12'hC00, "R4");

        cur_req = "R5";
        cfg(3, 2, 1000); chk(3, 12'h000, "R5");
        upd(3, 6, 'hFFFFFF); chk(3, 12'h000, "R5");
        upd(3, 7, 'hFFFFFF); chk(3, 12'h000, "R5");

        cur_req = "R7";
        drive(1, 2, 5, 10, 0, 0, 0, 0, 1, 2, 12'hC00);
        chk(2, 12'h400, "R7");

        cur_req = "R9";
        chk(4, 12'h000, "R9"); chk(0, 12'h300, "R9"); chk(1, 12'h00C, "R9");

        cur_req = "R10";
        cfg(5, 0, 500);
        drive(1, 5, 0, 100, 1, 5, 0, 10, 0, 0, 0);
        chk(5, 12'h000, "R10");
        upd(5, 0, 100); chk(5, 12'h001, "R10");

        cur_req = "R8";
        clr(0, 12'hFFF); clr(1, 12'hFFF); clr(2, 12'hFFF); clr(5, 12'hFFF);
        chk(5, 12'h000, "R6"); chk_any(1, "R8");
        idle(); chk_any(0, "R8");

        cur_req = "R2/R4/R6/R7/R10 random";
        for (int i = 0; i < 600; i++) begin
            int vv;
            vv = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 24'hFFFFFF))
                                             : int'($urandom_range(0, 400));
            drive($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7), vv,
                  $urandom_range(0, 3) == 0, $urandom_range(0, 7), $urandom_range(0, 3),
                  $urandom_range(0, 400),
                  $urandom_range(0, 4) == 0, $urandom_range(0, 7), $urandom_range(0, 12'hFFF));
        end
        idle();
        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule